// File: doc/BRIEF.md
# Low-Frequency Tag Link Engine

This block is the tag-side radio layer of a low-frequency, two-way link. The reader sends data by briefly switching off its field, and the tag sees a thresholded copy of that field on `field_in`. The block times the gap between successive rising edges of that signal in carrier periods. A qualifying `carrier_tick` marks each period. Each gap is sorted into a 0, a 1 or a frame break, and the bits are collected into a frame buffer.

If no edge arrives for longer than the end-of-frame limit, the collected frame is presented on `rx_frame`/`rx_len` together with a one-cycle `rx_done` strobe. A command layer outside this block reads the frame. It may then request a reply by pulsing `rsp_start` with the reply bits and their count. The block waits a fixed turnaround measured from the last reader edge, then drives `mod_out` with a Manchester-coded start bit followed by the reply bits. A high level on `mod_out` means the antenna is loaded.

Top module: `lf_link_engine`

## Requirements
- R1: A rising-edge interval of 24 to 40 carrier ticks, inclusive, decodes as a 1 bit.
- R2: A rising-edge interval of 15 to 23 carrier ticks, inclusive, decodes as a 0 bit.
- R3: An interval below 15 ticks, or an edge after the counter has passed 40, yields no bit and discards the partial frame. The edge that ended such an interval becomes the reference for a new frame.
- R4: On the 41st tick after the last accepted rising edge, the collected frame is handed off. `rx_done` is high for exactly one cycle, and it is not raised when no bit was collected.
- R5: The first received bit lands in `rx_frame[55]`, the next in `rx_frame[54]` and so on, so each byte reads MSB first. `rx_len` holds the bit count, and positions that were not received read 0.
- R6: Bits beyond the 56th are dropped, and `rx_len` saturates at 56.
- R7: When `rsp_start` arrives earlier, the first half of the start bit begins on the 200th tick after the last rising edge. This is the nominal 208 turnaround minus an 8-period gap.
- R8: A reply is a 1 start bit followed by `rsp_len` bits taken from `rsp_data[55]` downward. A `rsp_len` above 56 is treated as 56.
- R9: Each reply bit lasts 31 ticks and changes level after 15 ticks. A 1 is loaded (`mod_out`=1) and then unloaded, and a 0 is unloaded and then loaded. `mod_out` is 0 whenever no reply is being sent.
- R10: Rising edges on `field_in` during a reply neither alter the reply nor contribute bits or frames.
- R11: After reset `rx_done`, `rx_len`, `rx_frame` and `mod_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| field_in | input | 1 | Thresholded reader field, asynchronous |
| rsp_start | input | 1 | Request a reply; accepted only while idle |
| rsp_data | input | 56 | Reply bits, first bit in the top position |
| rsp_len | input | 6 | Number of reply bits after the start bit |
| rx_frame | output | 56 | Last received frame, first bit in the top position |
| rx_len | output | 6 | Bit count of the last received frame |
| rx_done | output | 1 | One-cycle strobe when a frame is handed off |
| mod_out | output | 1 | Load modulation, 1 = loaded |

## Verification
The assertions assume that `carrier_tick` is a single-cycle pulse separated by idle cycles. They also assume that a field edge, once synchronized, is never seen in the same cycle as a tick. The timing assertions depend on both. The stimulus drives ticks every fourth clock and changes `field_in` just after a tick, so each synchronized edge lands between two ticks. High pulses last three ticks, well inside the shortest interval. Replies are requested only after the frame has been handed off, so the turnaround always runs from the final reader edge.

// File: rtl/lf_link_pkg.sv
package lf_link_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO  = 2'd0,
        SYM_ONE   = 2'd1,
        SYM_BREAK = 2'd2
    } sym_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/lf_interval_classifier.sv
module lf_interval_classifier
    import lf_link_pkg::*;
#(
    parameter int T0_MIN      = 15,
    parameter int T1_MIN      = 24,
    parameter int T_EOF       = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic field_in,
    input  logic inhibit,
    output logic rise_o,
    output logic sym_valid_o,
    output sym_e sym_o,
    output logic eof_o
);
    localparam int CNT_W = $clog2(T_EOF + 2);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(T_EOF + 1);
    localparam logic [CNT_W-1:0] EOF_C  = CNT_W'(T_EOF);
    localparam logic [CNT_W-1:0] ZERO_C = CNT_W'(T0_MIN);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(T1_MIN);

    typedef struct packed {
        logic [SYNC_STAGES:0] sync;
        logic [CNT_W-1:0]     ivl;
        logic                 sym_valid;
        sym_e                 sym;
        logic                 eof;
    } cls_t;

    cls_t q, n;
    logic rise;

    always_comb begin
        n           = q;
        n.sync      = {q.sync[SYNC_STAGES-1:0], field_in};
        n.sym_valid = 1'b0;
        n.eof       = 1'b0;
        rise        = q.sync[SYNC_STAGES-1] & ~q.sync[SYNC_STAGES];
        if (rise && !inhibit) begin
            n.ivl       = '0;
            n.sym_valid = 1'b1;
            if (q.ivl < ZERO_C || q.ivl > EOF_C) begin
                n.sym = SYM_BREAK;
            end else if (q.ivl >= ONE_C) begin
                n.sym = SYM_ONE;
            end else begin
                n.sym = SYM_ZERO;
            end
        end else if (tick && q.ivl != SAT_C) begin
            n.ivl = q.ivl + CNT_W'(1);
            if (q.ivl == EOF_C) begin
                n.eof = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.ivl <= SAT_C;
        end else begin
            q <= n;
        end
    end

    assign rise_o      = rise;
    assign sym_valid_o = q.sym_valid;
    assign sym_o       = q.sym;
    assign eof_o       = q.eof;

    // R4: the end-of-frame strobe is a single pulse and leaves the counter saturated
    a_r4_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);
    a_r4_eof_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> q.ivl == SAT_C);

endmodule

// File: rtl/lf_frame_packer.sv
module lf_frame_packer
    import lf_link_pkg::*;
#(
    parameter int BUF_BITS = 56
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sym_valid,
    input  sym_e                        sym,
    input  logic                        eof,
    output logic [BUF_BITS-1:0]         frame_o,
    output logic [$clog2(BUF_BITS+1)-1:0] len_o,
    output logic                        done_o
);
    localparam int LEN_W = $clog2(BUF_BITS + 1);
    localparam logic [LEN_W-1:0]    FULL_C = LEN_W'(BUF_BITS);
    localparam logic [BUF_BITS-1:0] TOP_C  = {1'b1, {(BUF_BITS-1){1'b0}}};

    typedef struct packed {
        logic [BUF_BITS-1:0] acc;
        logic [LEN_W-1:0]    pos;
        logic [BUF_BITS-1:0] frame;
        logic [LEN_W-1:0]    len;
        logic                done;
    } pk_t;

    pk_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (eof) begin
            if (q.pos != '0) begin
                n.frame = q.acc;
                n.len   = q.pos;
                n.done  = 1'b1;
            end
            n.acc = '0;
            n.pos = '0;
        end else if (sym_valid) begin
            if (sym == SYM_BREAK) begin
                n.acc = '0;
                n.pos = '0;
            end else if (q.pos != FULL_C) begin
                if (sym == SYM_ONE) begin
                    n.acc = q.acc | (TOP_C >> q.pos);
                end
                n.pos = q.pos + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign frame_o = q.frame;
    assign len_o   = q.len;
    assign done_o  = q.done;

    // R4: hand-off strobe lasts one cycle and never carries an empty frame
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r4_done_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> len_o != '0);
    // R6: the bit position never runs past the buffer
    a_r6_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= FULL_C);

endmodule

// File: rtl/lf_manchester_tx.sv
module lf_manchester_tx
    import lf_link_pkg::*;
#(
    parameter int BUF_BITS = 56,
    parameter int WAIT     = 200,
    parameter int HALF     = 15,
    parameter int BIT_END  = 31
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          rise,
    input  logic                          rsp_start,
    input  logic [BUF_BITS-1:0]           rsp_data,
    input  logic [$clog2(BUF_BITS+1)-1:0] rsp_len,
    output logic                          mod_o,
    output logic                          busy_o
);
    localparam int LEN_W   = $clog2(BUF_BITS + 1);
    localparam int LEFT_W  = $clog2(BUF_BITS + 2);
    localparam int SINCE_W = $clog2(WAIT + 1);
    localparam int TMR_W   = $clog2(BIT_END + 1);
    localparam logic [LEN_W-1:0]   FULL_C  = LEN_W'(BUF_BITS);
    localparam logic [SINCE_W-1:0] WAIT_C  = SINCE_W'(WAIT);
    localparam logic [SINCE_W-1:0] GO_C    = SINCE_W'(WAIT - 1);
    localparam logic [TMR_W-1:0]   HALF_C  = TMR_W'(HALF);
    localparam logic [TMR_W-1:0]   LAST_C  = TMR_W'(BIT_END - 1);

    typedef struct packed {
        tx_state_e           st;
        logic [SINCE_W-1:0]  since;
        logic [BUF_BITS:0]   sh;
        logic [LEN_W-1:0]    len;
        logic [LEFT_W-1:0]   left;
        logic [TMR_W-1:0]    tmr;
        logic                mod;
    } tx_t;

    tx_t q, n;

    always_comb begin
        n = q;
        if (q.st != TX_SEND) begin
            if (rise) begin
                n.since = '0;
            end else if (tick && q.since != WAIT_C) begin
                n.since = q.since + SINCE_W'(1);
            end
        end
        case (q.st)
            TX_IDLE: begin
                if (rsp_start) begin
                    n.st  = TX_ARMED;
                    n.len = (rsp_len > FULL_C) ? FULL_C : rsp_len;
                    n.sh  = {1'b1, rsp_data};
                end
            end
            TX_ARMED: begin
                if (!rise && tick && q.since >= GO_C) begin
                    n.st   = TX_SEND;
                    n.tmr  = '0;
                    n.left = LEFT_W'(q.len) + LEFT_W'(1);
                end
            end
            TX_SEND: begin
                if (tick) begin
                    if (q.tmr == LAST_C) begin
                        n.tmr  = '0;
                        n.sh   = {q.sh[BUF_BITS-1:0], 1'b0};
                        n.left = q.left - LEFT_W'(1);
                        if (q.left == LEFT_W'(1)) begin
                            n.st = TX_IDLE;
                        end
                    end else begin
                        n.tmr = q.tmr + TMR_W'(1);
                    end
                end
            end
            default: n.st = TX_IDLE;
        endcase
        n.mod = (n.st == TX_SEND) &&
                (n.sh[BUF_BITS] ? (n.tmr < HALF_C) : (n.tmr >= HALF_C));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign mod_o  = q.mod;
    assign busy_o = (q.st == TX_SEND);

    // R9: modulation moves only on carrier ticks and is quiet outside a reply
    a_r9_mod_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mod_o));
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != TX_SEND) |-> !mod_o);
    // R7: a reply only begins once the turnaround has elapsed
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(q.since) >= GO_C);

endmodule

// File: rtl/lf_link_engine.sv
module lf_link_engine
    import lf_link_pkg::*;
#(
    parameter int BUF_BITS    = 56,
    parameter int T0_MIN      = 15,
    parameter int T1_MIN      = 24,
    parameter int T_EOF       = 40,
    parameter int FDT         = 208,
    parameter int FDT_GAP     = 8,
    parameter int HALF        = 15,
    parameter int BIT_END     = 31,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(BUF_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                carrier_tick,
    input  logic                field_in,
    input  logic                rsp_start,
    input  logic [BUF_BITS-1:0] rsp_data,
    input  logic [LEN_W-1:0]    rsp_len,
    output logic [BUF_BITS-1:0] rx_frame,
    output logic [LEN_W-1:0]    rx_len,
    output logic                rx_done,
    output logic                mod_out
);
    localparam int RESP_WAIT = FDT - FDT_GAP;

    logic rise;
    logic sym_valid;
    sym_e sym;
    logic eof;
    logic tx_busy;

    lf_interval_classifier #(
        .T0_MIN     (T0_MIN),
        .T1_MIN     (T1_MIN),
        .T_EOF      (T_EOF),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (carrier_tick),
        .field_in   (field_in),
        .inhibit    (tx_busy),
        .rise_o     (rise),
        .sym_valid_o(sym_valid),
        .sym_o      (sym),
        .eof_o      (eof)
    );

    lf_frame_packer #(
        .BUF_BITS(BUF_BITS)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_valid(sym_valid),
        .sym      (sym),
        .eof      (eof),
        .frame_o  (rx_frame),
        .len_o    (rx_len),
        .done_o   (rx_done)
    );

    lf_manchester_tx #(
        .BUF_BITS(BUF_BITS),
        .WAIT    (RESP_WAIT),
        .HALF    (HALF),
        .BIT_END (BIT_END)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (carrier_tick),
        .rise     (rise),
        .rsp_start(rsp_start),
        .rsp_data (rsp_data),
        .rsp_len  (rsp_len),
        .mod_o    (mod_out),
        .busy_o   (tx_busy)
    );

    // R10: no symbol reaches the packer while a reply is on the air
    a_r10_no_sym_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !sym_valid);
    // R4: a frame hand-off never coincides with a reply in progress
    a_r4_no_done_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_done);

endmodule

// File: tb/lf_link_engine_test.sv
module lf_link_engine_test;

    localparam int BUF  = 56;
    localparam int LW   = 6;
    localparam int WAIT = 200;
    localparam int HLF  = 15;
    localparam int BITL = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_in = 1'b0;
    logic rsp_start = 1'b0;
    logic [BUF-1:0] rsp_data = '0;
    logic [LW-1:0]  rsp_len = '0;
    logic [BUF-1:0] rx_frame;
    logic [LW-1:0]  rx_len;
    logic rx_done;
    logic mod_out;
    logic [1:0] div = 2'd0;
    logic carrier_tick;

    int n_chk = 0;
    int n_fail = 0;
    int tcount = 0;
    int done_cnt = 0;
    int ivls[64];
    int nivl = 0;

    // nbits[135:128] bits[127:64] rlen[63:56] rdata[55:0]
    localparam logic [135:0] VEC [4] = '{
        {8'd8,  64'hA500_0000_0000_0000, 8'd8,  56'h3C00_0000_0000_00},
        {8'd16, 64'h1234_0000_0000_0000, 8'd12, 56'hF0F0_0000_0000_00},
        {8'd3,  64'hA000_0000_0000_0000, 8'd0,  56'h0000_0000_0000_00},
        {8'd60, 64'hDEAD_BEEF_0123_4567, 8'd56, 56'h8000_0000_0000_01}
    };

    always #2 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign carrier_tick = (div == 2'd3);
    always @(negedge clk) if (rst_n && rx_done) done_cnt++;

    lf_link_engine uut (
        .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .field_in(field_in),
        .rsp_start(rsp_start), .rsp_data(rsp_data), .rsp_len(rsp_len),
        .rx_frame(rx_frame), .rx_len(rx_len), .rx_done(rx_done), .mod_out(mod_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_tick();
        do @(negedge clk); while (!carrier_tick);
        @(posedge clk);
        #1;
        tcount++;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) next_tick();
    endtask

    task automatic send_ivls();
        field_in = 1'b1;
        tcount = 0;
        for (int i = 0; i < nivl; i++) begin
            ticks(3);
            field_in = 1'b0;
            ticks(ivls[i] - 3);
            field_in = 1'b1;
            tcount = 0;
        end
        ticks(3);
        field_in = 1'b0;
    endtask

    task automatic finish_rx(input int elen, input logic [BUF-1:0] efr, input string req);
        int base;
        base = done_cnt;
        while (tcount < 40) next_tick();
        chk(done_cnt == base, "R4 no hand-off before tick 41", 64'(done_cnt - base), 64'd0);
        next_tick();
        repeat (3) @(posedge clk);
        #1;
        chk(done_cnt == base + 1, "R4 single hand-off at tick 41", 64'(done_cnt - base), 64'd1);
        chk(rx_len == LW'(elen), {req, " length"}, 64'(rx_len), 64'(elen));
        chk(rx_frame == efr, {req, " frame"}, 64'(rx_frame), 64'(efr));
    endtask

    task automatic run_reply(input int rlen, input logic [BUF-1:0] rdata, input bit disturb);
        int stop, k, tm;
        bit bv, expv;
        while (tcount < 45) next_tick();
        rsp_data = rdata;
        rsp_len = LW'(rlen);
        rsp_start = 1'b1;
        @(posedge clk);
        #1;
        rsp_start = 1'b0;
        stop = WAIT + BITL * (rlen + 1) + 3;
        while (tcount < stop) begin
            next_tick();
            if (disturb) begin
                if (tcount == 220 || tcount == 240) field_in = 1'b1;
                if (tcount == 223 || tcount == 243) field_in = 1'b0;
            end
            if (tcount < WAIT) begin
                expv = 1'b0;
            end else begin
                k = (tcount - WAIT) / BITL;
                tm = (tcount - WAIT) % BITL;
                if (k > rlen) begin
                    expv = 1'b0;
                end else begin
                    bv = (k == 0) ? 1'b1 : rdata[BUF - k];
                    expv = bv ? (tm < HLF) : (tm >= HLF);
                end
            end
            // R7 start at tick 200, R8 bit order, R9 half-bit levels
            chk(mod_out == expv, $sformatf("R7/R8/R9 mod_out at tick %0d", tcount),
                64'(mod_out), 64'(expv));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int nb, rl, el, base;
        logic [63:0] bits;
        logic [BUF-1:0] rd, efr;
        repeat (5) @(posedge clk);
        #1;
        chk(rx_done == 1'b0, "R11 reset rx_done", 64'(rx_done), 64'd0);
        chk(rx_len == '0, "R11 reset rx_len", 64'(rx_len), 64'd0);
        chk(rx_frame == '0, "R11 reset rx_frame", 64'(rx_frame), 64'd0);
        chk(mod_out == 1'b0, "R11 reset mod_out", 64'(mod_out), 64'd0);
        rst_n = 1'b1;
        ticks(5);

        // table walk: R1 R2 R5 R6 receive, R7 R8 R9 reply
        for (int v = 0; v < 4; v++) begin
            nb = int'(VEC[v][135:128]);
            bits = VEC[v][127:64];
            rl = int'(VEC[v][63:56]);
            rd = VEC[v][55:0];
            nivl = nb;
            for (int i = 0; i < nb; i++) ivls[i] = bits[63 - i] ? 26 : 20;
            el = (nb > BUF) ? BUF : nb;
            efr = bits[63:8] & ~({BUF{1'b1}} >> el);
            send_ivls();
            finish_rx(el, efr, $sformatf("R1/R2/R5/R6 vector %0d", v));
            run_reply(rl, rd, 1'b0);
            ticks(10);
        end

        // R3: short interval discards the partial frame
        nivl = 6;
        ivls[0] = 26; ivls[1] = 20; ivls[2] = 26; ivls[3] = 10; ivls[4] = 20; ivls[5] = 26;
        send_ivls();
        finish_rx(2, 56'h4000_0000_0000_00, "R3 restart after short interval");
        ticks(10);

        // R1 R2 boundaries: 15 and 23 are zeros, 24 and 40 are ones
        nivl = 4;
        ivls[0] = 15; ivls[1] = 23; ivls[2] = 24; ivls[3] = 40;
        send_ivls();
        finish_rx(4, 56'h3000_0000_0000_00, "R1/R2 boundary intervals");
        ticks(10);

        // R3: 14 ticks is a break
        nivl = 3;
        ivls[0] = 20; ivls[1] = 14; ivls[2] = 26;
        send_ivls();
        finish_rx(1, 56'h8000_0000_0000_00, "R3 interval 14 breaks");
        ticks(10);

        // R4: a lone edge gives no hand-off
        base = done_cnt;
        nivl = 0;
        send_ivls();
        ticks(60);
        chk(done_cnt == base, "R4 empty frame not handed off", 64'(done_cnt - base), 64'd0);
        chk(rx_len == LW'(1), "R4 previous length held", 64'(rx_len), 64'd1);

        // R10: edges during a reply are ignored
        nivl = 2;
        ivls[0] = 26; ivls[1] = 20;
        send_ivls();
        finish_rx(2, 56'h8000_0000_0000_00, "R10 setup frame");
        run_reply(8, 56'h5A00_0000_0000_00, 1'b1);
        base = done_cnt;
        ticks(100);
        chk(done_cnt == base, "R10 no frame from edges during reply", 64'(done_cnt - base), 64'd0);
        chk(mod_out == 1'b0, "R9 idle after reply", 64'(mod_out), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule